// File: doc/BRIEF.md
# Interrupt Vector Relocation Selector

This block decides where a 64-bit processor begins executing when it takes an interrupt, and whether translation is switched on at entry. It combines a generation selector, a two-bit alternate-location field and a separate hypervisor relocation enable (both held in a partition control register), a radix-host flag, the machine state at the moment of the interrupt (instruction relocation, data relocation, hypervisor), the hypervisor state the handler will run in, and an interrupt class. From these it chooses an effective location mode, applies the matching offset to the supplied base vector, and forces both relocation bits on whenever the mode is nonzero.

Each generation uses its own decision matrix. The oldest generation never relocates. The classic generation relocates only when both relocation bits were on. It also blocks relocation on a guest-to-hypervisor entry unless the host is in radix mode. The newest generation drops one location encoding. It drives every hypervisor-state entry from the dedicated enable, and it applies the translation test only when the hypervisor state does not change. The decision logic is combinational. A single register stage captures the result when the valid strobe is high.

Top module: `irq_vec_reloc`

## Requirements
- R1: While rst_n is low, and after reset until the first strobe, vec_out, loc_mode_out and xlate_force_out are all zero.
- R2: The location field is decoded as follows: value 0 gives no offset and value 2 adds 0x1_8000 to the base vector. Value 3 ORs 0xC000_0000_0000_4000 into the base. Value 1 is reserved and acts as 0. loc_mode_out reports the effective mode.
- R3: With gen_sel=2 (newest), a location field of 2 acts as 0.
- R4: With gen_sel=2 and new_hv=1, the mode is 3 when hv_loc_en=1 and 0 when hv_loc_en=0, regardless of the location field.
- R5: irq_class=1 (non-relocatable: reset, machine check, maintenance) and the reserved irq_class=3 always give mode 0, vec_out equal to base_vec, and no forced relocation.
- R6: With gen_sel=1 (classic), the mode is 0 unless cur_ir and cur_dr are both 1.
- R7: With gen_sel=1, an entry with cur_hv=0 and new_hv=1 gets mode 0 unless radix_host=1. With radix_host=1 it uses the location field.
- R8: With gen_sel=2, the relocation test on cur_ir/cur_dr applies only when new_hv equals cur_hv. A guest-to-hypervisor entry follows hv_loc_en whatever the relocation bits are.
- R9: The effective mode is the hypervisor-side value when new_hv=1 and the regular value otherwise. With gen_sel=1, both values start from the location field.
- R10: xlate_force_out (bit 1 instruction, bit 0 data) is 2'b11 when the effective mode is nonzero and 2'b00 otherwise.
- R11: irq_class=2 (system call vectored) ignores the normal offsets. It ORs 0xC000_0000_0000_3000 into the base when the mode is 3, and 0x1_7000 otherwise.
- R12: gen_sel=0 (oldest) and gen_sel=3 (unsupported) always give mode 0.
- R13: Outputs change only at a rising clock edge where in_valid=1, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the output stage |
| gen_sel | input | 2 | Generation: 0 oldest, 1 classic, 2 newest, 3 unsupported |
| loc_field | input | 2 | Alternate-location field |
| hv_loc_en | input | 1 | Hypervisor relocation enable (newest generation) |
| radix_host | input | 1 | Radix-host mode flag |
| cur_ir | input | 1 | Instruction relocation at interrupt time |
| cur_dr | input | 1 | Data relocation at interrupt time |
| cur_hv | input | 1 | Hypervisor state at interrupt time |
| new_hv | input | 1 | Hypervisor state of the handler |
| irq_class | input | 2 | 0 normal, 1 non-relocatable, 2 system call vectored, 3 reserved |
| base_vec | input | 64 | Unrelocated vector |
| vec_out | output | 64 | Final entry address |
| loc_mode_out | output | 2 | Effective location mode |
| xlate_force_out | output | 2 | Forced relocation bits {instruction, data} |

## Verification
Two functions can meet on one capture: the generation-specific suppression of the mode, and the class-specific vector construction that consumes that mode. A system-call-vectored entry that also meets a suppression condition in the newest generation must switch to the 0x1_7000 offset and drop forced translation in the same cycle. Directed cases build these collisions: the reserved location value, a guest-to-hypervisor entry with relocation off, and a non-relocatable class with every enable set. Seeded random vectors cover the rest of the matrix. Every captured vector, mode and force pair is compared with a bench model written from the requirements.

// File: rtl/irv_pkg.sv
package irv_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    GEN_OLDEST  = 2'd0,
    GEN_CLASSIC = 2'd1,
    GEN_NEWEST  = 2'd2,
    GEN_UNSUP   = 2'd3
  } gen_e;

  typedef enum logic [1:0] {
    CLS_NORMAL  = 2'd0,
    CLS_NOREL   = 2'd1,
    CLS_SCV     = 2'd2,
    CLS_RSVD    = 2'd3
  } cls_e;

  localparam logic [XLEN-1:0] OFS_MODE2   = 64'h0000_0000_0001_8000;
  localparam logic [XLEN-1:0] OFS_MODE3   = 64'hC000_0000_0000_4000;
  localparam logic [XLEN-1:0] SCV_HIGH    = 64'hC000_0000_0000_3000;
  localparam logic [XLEN-1:0] SCV_LOW     = 64'h0000_0000_0001_7000;

  // Normalise the location field: value 1 is always reserved,
  // value 2 is reserved in the newest generation.
  function automatic logic [1:0] norm_loc(input gen_e g, input logic [1:0] l);
    logic [1:0] r;
    r = l;
    if (l == 2'd1) r = 2'd0;
    if (g == GEN_NEWEST && l == 2'd2) r = 2'd0;
    return r;
  endfunction

  // Vector construction for a given class and effective mode.
  function automatic logic [XLEN-1:0] build_vec(input cls_e c, input logic [1:0] m,
                                                input logic [XLEN-1:0] b);
    logic [XLEN-1:0] v;
    v = b;
    if (c == CLS_SCV) begin
      v = (m == 2'd3) ? (b | SCV_HIGH) : (b | SCV_LOW);
    end else if (c == CLS_NORMAL) begin
      case (m)
        2'd2:    v = b + OFS_MODE2;
        2'd3:    v = b | OFS_MODE3;
        default: v = b;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/irv_mode_core.sv
module irv_mode_core
  import irv_pkg::*;
(
  input  gen_e       gen,
  input  cls_e       cls,
  input  logic [1:0] loc,
  input  logic       hv_en,
  input  logic       radix,
  input  logic       ir,
  input  logic       dr,
  input  logic       cur_hv,
  input  logic       new_hv,
  output logic [1:0] eff_mode,
  output logic       xlate_on,
  output logic       hv_change
);
  logic [1:0] loc_n;
  logic [1:0] reg_mode;
  logic [1:0] hyp_mode;
  logic       relocatable;

  assign loc_n       = norm_loc(gen, loc);
  assign xlate_on    = ir & dr;
  assign hv_change   = new_hv ^ cur_hv;
  assign relocatable = (cls == CLS_NORMAL) || (cls == CLS_SCV);

  always_comb begin
    reg_mode = 2'd0;
    hyp_mode = 2'd0;
    case (gen)
      GEN_CLASSIC: begin
        reg_mode = loc_n;
        hyp_mode = loc_n;
        if (!xlate_on) begin
          reg_mode = 2'd0;
          hyp_mode = 2'd0;
        end else if (new_hv && !cur_hv && !radix) begin
          hyp_mode = 2'd0;
        end
      end
      GEN_NEWEST: begin
        reg_mode = loc_n;
        hyp_mode = hv_en ? 2'd3 : 2'd0;
        if (!hv_change && !xlate_on) begin
          reg_mode = 2'd0;
          hyp_mode = 2'd0;
        end
      end
      default: begin
        reg_mode = 2'd0;
        hyp_mode = 2'd0;
      end
    endcase
    if (!relocatable) begin
      reg_mode = 2'd0;
      hyp_mode = 2'd0;
    end
  end

  assign eff_mode = new_hv ? hyp_mode : reg_mode;
endmodule

// File: rtl/irv_vec_build.sv
module irv_vec_build
  import irv_pkg::*;
(
  input  cls_e            cls,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] base,
  output logic [XLEN-1:0] vec,
  output logic [1:0]      force_bits
);
  assign vec        = build_vec(cls, mode, base);
  assign force_bits = (mode != 2'd0) ? 2'b11 : 2'b00;
endmodule

// File: rtl/irv_out_reg.sv
module irv_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc
  import irv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  gen_sel,
  input  logic [1:0]  loc_field,
  input  logic        hv_loc_en,
  input  logic        radix_host,
  input  logic        cur_ir,
  input  logic        cur_dr,
  input  logic        cur_hv,
  input  logic        new_hv,
  input  logic [1:0]  irq_class,
  input  logic [63:0] base_vec,
  output logic [63:0] vec_out,
  output logic [1:0]  loc_mode_out,
  output logic [1:0]  xlate_force_out
);
  localparam int PACK_W = XLEN + 4;

  gen_e            gen;
  cls_e            cls;
  logic [1:0]      eff_mode;
  logic            xlate_on;
  logic            hv_change;
  logic [XLEN-1:0] vec_d;
  logic [1:0]      force_d;
  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  assign gen = gen_e'(gen_sel);
  assign cls = cls_e'(irq_class);

  irv_mode_core u_mode (
    .gen       (gen),
    .cls       (cls),
    .loc       (loc_field),
    .hv_en     (hv_loc_en),
    .radix     (radix_host),
    .ir        (cur_ir),
    .dr        (cur_dr),
    .cur_hv    (cur_hv),
    .new_hv    (new_hv),
    .eff_mode  (eff_mode),
    .xlate_on  (xlate_on),
    .hv_change (hv_change)
  );

  irv_vec_build u_vec (
    .cls        (cls),
    .mode       (eff_mode),
    .base       (base_vec),
    .vec        (vec_d),
    .force_bits (force_d)
  );

  assign pack_d = {vec_d, eff_mode, force_d};

  irv_out_reg #(.W(PACK_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .d     (pack_d),
    .q     (pack_q)
  );

  assign vec_out         = pack_q[PACK_W-1:4];
  assign loc_mode_out    = pack_q[3:2];
  assign xlate_force_out = pack_q[1:0];
endmodule

// File: rtl/irv_chk.sv
module irv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  gen_sel,
  input logic [1:0]  loc_field,
  input logic [1:0]  irq_class,
  input logic        new_hv,
  input logic        xlate_on,
  input logic        hv_change,
  input logic [1:0]  eff_mode,
  input logic [63:0] vec_out,
  input logic [1:0]  loc_mode_out,
  input logic [1:0]  xlate_force_out
);
  // R10
  force_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_force_out == ((loc_mode_out != 2'd0) ? 2'b11 : 2'b00));

  // R5
  norel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && irq_class[0]) |=> (loc_mode_out == 2'd0));

  // R12
  oldgen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (gen_sel == 2'd0 || gen_sel == 2'd3)) |=> (loc_mode_out == 2'd0));

  // R3
  rsvd_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_sel == 2'd2 && loc_field == 2'd2 && !new_hv) |-> (eff_mode == 2'd0));

  // R6
  classic_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_sel == 2'd1 && !xlate_on) |-> (eff_mode == 2'd0));

  // R8
  newest_same_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_sel == 2'd2 && !hv_change && !xlate_on) |-> (eff_mode == 2'd0));

  // R11
  scv_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && irq_class == 2'd2 && eff_mode == 2'd3) |=> (vec_out[63:62] == 2'b11));

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vec_out) && $stable(loc_mode_out)));
endmodule

bind irq_vec_reloc irv_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .gen_sel         (gen_sel),
  .loc_field       (loc_field),
  .irq_class       (irq_class),
  .new_hv          (new_hv),
  .xlate_on        (xlate_on),
  .hv_change       (hv_change),
  .eff_mode        (eff_mode),
  .vec_out         (vec_out),
  .loc_mode_out    (loc_mode_out),
  .xlate_force_out (xlate_force_out)
);

// File: tb/test_irq_vec_reloc.sv
module test_irq_vec_reloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  gen_sel = '0;
  logic [1:0]  loc_field = '0;
  logic        hv_loc_en = 1'b0;
  logic        radix_host = 1'b0;
  logic        cur_ir = 1'b0;
  logic        cur_dr = 1'b0;
  logic        cur_hv = 1'b0;
  logic        new_hv = 1'b0;
  logic [1:0]  irq_class = '0;
  logic [63:0] base_vec = '0;
  logic [63:0] vec_out;
  logic [1:0]  loc_mode_out;
  logic [1:0]  xlate_force_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_reloc i_irq_vec_reloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_sel(gen_sel),
    .loc_field(loc_field), .hv_loc_en(hv_loc_en), .radix_host(radix_host),
    .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv), .new_hv(new_hv),
    .irq_class(irq_class), .base_vec(base_vec), .vec_out(vec_out),
    .loc_mode_out(loc_mode_out), .xlate_force_out(xlate_force_out)
  );

  // Model of the effective mode, written as a per-case lookup.
  function automatic logic [1:0] exp_mode();
    logic [1:0] m;
    logic both;
    both = cur_ir && cur_dr;
    m = 2'd0;
    if (irq_class == 2'd1 || irq_class == 2'd3) return 2'd0;           // R5
    if (gen_sel == 2'd1) begin                                        // R6 R7 R9
      m = (loc_field == 2'd1) ? 2'd0 : loc_field;
      if (!both) m = 2'd0;
      else if (new_hv && !cur_hv && !radix_host) m = 2'd0;
    end else if (gen_sel == 2'd2) begin                               // R3 R4 R8
      if (new_hv) m = hv_loc_en ? 2'd3 : 2'd0;
      else m = (loc_field == 2'd3) ? 2'd3 : 2'd0;
      if (new_hv == cur_hv && !both) m = 2'd0;
    end
    return m;                                                         // R12
  endfunction

  function automatic logic [63:0] exp_vec(input logic [1:0] m);
    if (irq_class == 2'd2)                                            // R11
      return (m == 2'd3) ? {2'b11, base_vec[61:0]} | 64'h3000 : base_vec | 64'h17000;
    if (irq_class != 2'd0) return base_vec;
    if (m == 2'd2) return base_vec + 64'h18000;                       // R2
    if (m == 2'd3) return base_vec | 64'hC000_0000_0000_4000;
    return base_vec;
  endfunction

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply at negedge with strobe; results registered at next posedge, checked at next negedge.
  task automatic apply(input string req, input logic [1:0] g, input logic [1:0] l,
                       input logic he, input logic rx, input logic ir, input logic dr,
                       input logic ch, input logic nh, input logic [1:0] c, input logic [63:0] b);
    logic [1:0]  m;
    logic [63:0] v;
    @(negedge clk);
    gen_sel = g; loc_field = l; hv_loc_en = he; radix_host = rx;
    cur_ir = ir; cur_dr = dr; cur_hv = ch; new_hv = nh; irq_class = c; base_vec = b;
    in_valid = 1'b1;
    m = exp_mode();
    v = exp_vec(m);
    @(negedge clk);
    in_valid = 1'b0;
    cmp({req, " mode"}, {62'd0, loc_mode_out}, {62'd0, m});
    cmp({req, " vec"}, vec_out, v);
    cmp({req, " R10 force"}, {62'd0, xlate_force_out}, (m != 0) ? 64'd3 : 64'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_v;
    logic [1:0]  hold_m;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1 vec", vec_out, 64'd0);
    cmp("R1 mode", {62'd0, loc_mode_out}, 64'd0);
    cmp("R1 force", {62'd0, xlate_force_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", vec_out, 64'd0);

    // Directed corners
    apply("R2 mode2 classic", 2'd1, 2'd2, 1'b0, 1'b0, 1, 1, 0, 0, 2'd0, 64'h900);
    cmp("R2 vec value", vec_out, 64'h18900);
    apply("R2 mode3 classic", 2'd1, 2'd3, 1'b0, 1'b0, 1, 1, 1, 1, 2'd0, 64'h500);
    cmp("R2 vec value3", vec_out, 64'hC000_0000_0000_4500);
    apply("R2 loc1 reserved", 2'd1, 2'd1, 1'b0, 1'b0, 1, 1, 0, 0, 2'd0, 64'h300);
    apply("R3 newest loc2", 2'd2, 2'd2, 1'b1, 1'b0, 1, 1, 0, 0, 2'd0, 64'h700);
    cmp("R3 mode zero", {62'd0, loc_mode_out}, 64'd0);
    apply("R4 newest hv en", 2'd2, 2'd0, 1'b1, 1'b0, 1, 1, 1, 1, 2'd0, 64'h980);
    cmp("R4 mode three", {62'd0, loc_mode_out}, 64'd3);
    apply("R4 newest hv dis", 2'd2, 2'd3, 1'b0, 1'b0, 1, 1, 1, 1, 2'd0, 64'h980);
    apply("R5 norel all set", 2'd2, 2'd3, 1'b1, 1'b1, 1, 1, 1, 1, 2'd1, 64'h100);
    cmp("R5 vec is base", vec_out, 64'h100);
    apply("R5 reserved class", 2'd1, 2'd3, 1'b1, 1'b1, 1, 1, 0, 0, 2'd3, 64'h200);
    apply("R6 classic ir only", 2'd1, 2'd3, 1'b0, 1'b1, 1, 0, 0, 0, 2'd0, 64'h400);
    apply("R7 classic g2h no radix", 2'd1, 2'd3, 1'b0, 1'b0, 1, 1, 0, 1, 2'd0, 64'h500);
    apply("R7 classic g2h radix", 2'd1, 2'd3, 1'b0, 1'b1, 1, 1, 0, 1, 2'd0, 64'h500);
    cmp("R7 radix mode3", {62'd0, loc_mode_out}, 64'd3);
    apply("R8 newest g2h xlate off", 2'd2, 2'd0, 1'b1, 1'b0, 0, 0, 0, 1, 2'd0, 64'h500);
    cmp("R8 mode three", {62'd0, loc_mode_out}, 64'd3);
    apply("R8 newest same hv off", 2'd2, 2'd3, 1'b1, 1'b0, 0, 1, 0, 0, 2'd0, 64'h500);
    apply("R9 classic hv1 to 1", 2'd1, 2'd2, 1'b0, 1'b0, 1, 1, 1, 1, 2'd0, 64'h600);
    apply("R11 scv mode3", 2'd2, 2'd0, 1'b1, 1'b0, 1, 1, 1, 1, 2'd2, 64'h0);
    cmp("R11 scv high", vec_out, 64'hC000_0000_0000_3000);
    apply("R11 scv suppressed", 2'd2, 2'd3, 1'b1, 1'b0, 0, 0, 0, 0, 2'd2, 64'h0);
    cmp("R11 scv low", vec_out, 64'h17000);
    apply("R11 scv mode2", 2'd1, 2'd2, 1'b0, 1'b0, 1, 1, 0, 0, 2'd2, 64'h0);
    apply("R12 oldest", 2'd0, 2'd3, 1'b1, 1'b1, 1, 1, 1, 1, 2'd0, 64'h800);
    apply("R12 unsupported", 2'd3, 2'd3, 1'b1, 1'b1, 1, 1, 0, 0, 2'd0, 64'h800);

    // R13 hold without strobe
    apply("R13 setup", 2'd1, 2'd3, 1'b0, 1'b0, 1, 1, 0, 0, 2'd0, 64'hA00);
    hold_v = vec_out; hold_m = loc_mode_out;
    @(negedge clk);
    gen_sel = 2'd0; base_vec = 64'h1234; irq_class = 2'd1;
    repeat (2) @(negedge clk);
    cmp("R13 vec held", vec_out, hold_v);
    cmp("R13 mode held", {62'd0, loc_mode_out}, {62'd0, hold_m});

    // Constrained random
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      apply("R9 random", 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            {44'd0, 8'($urandom) , 12'h0} >> 4);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule